// File: doc/BRIEF.md
# Shift-and-Add RGB to YCbCr Pixel Converter

This block turns a stream of 8-bit-per-channel RGB pixels into studio-range luma and the two colour-difference components. It accepts one pixel per clock. Each output is a fixed weighted sum of the three inputs, and every weight is a short sum of powers of two. The arithmetic is therefore only shifts, signed additions and signed subtractions, with no multiplier anywhere in the datapath.

Each of the three output channels has its own lane. A lane adds its shifted terms, divides the result by 2048 with an arithmetic right shift that rounds toward negative infinity, adds the channel offset, and clamps the value to the 8-bit range. The lanes run in parallel from the same input pixel. Each lane is cut into five register-separated stages, so a result appears five clocks after its pixel, and a new pixel can enter on every clock. A valid flag travels alongside the data, and the active-low asynchronous reset clears only that flag.

Top module: `rgb_ycc_shiftadd`

## Requirements
- R1: The luma output equals floor((512·R + 1020·G + 224·B) / 2048) + 16. The weights are the sum of G shifted left by 2 to 9, plus R shifted left by 9, plus B shifted left by 5, 6 and 7. An all-zero pixel gives luma 16.
- R2: The blue-difference output equals floor((900·B − 300·R − 592·G) / 2048) + 128. The B shifts are 2, 7, 8 and 9, the R shifts are 2, 3, 5 and 8, and the G shifts are 4, 6 and 9. An all-zero pixel gives 128.
- R3: The red-difference output equals floor((913·R − 768·G − 144·B) / 2048) + 128. The R shifts are 0, 4, 7, 8 and 9, the G shifts are 8 and 9, and the B shifts are 4 and 7. An all-zero pixel gives 128.
- R4: Negative sums round toward negative infinity. Pixel (R=1, G=0, B=0) gives blue-difference 127, and pixel (0, 0, 1) gives red-difference 127.
- R5: For every input pixel, luma lies in 16..234, blue-difference lies in 16..240 and red-difference lies in 14..241. Results are clamped to 0..255.
- R6: out_valid_o equals in_valid_i delayed by exactly five clocks, and the three data outputs carry that pixel's results in the same cycle.
- R7: Pixels presented on consecutive clocks, or with gaps of any length, each produce their own independent result. No pixel is lost or merged with another.
- R8: While rst_ni is low, out_valid_o is low. After release, it stays low until the first valid pixel has passed through all five stages. Pixels that were in flight when reset was asserted produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, clears valid flags |
| in_valid_i | input | 1 | Input pixel is present |
| red_i | input | 8 | Red sample, unsigned |
| grn_i | input | 8 | Green sample, unsigned |
| blu_i | input | 8 | Blue sample, unsigned |
| out_valid_o | output | 1 | Output pixel is present |
| luma_o | output | 8 | Luma result |
| cb_o | output | 8 | Blue-difference result |
| cr_o | output | 8 | Red-difference result |

## Verification
The assertions assume two things about the inputs. First, the colour samples are never unknown on a cycle where in_valid_i is high. Second, rst_ni is held low before the first clock edge, so the count of edges since reset that limits the five-deep history starts from a known point.

The stimulus meets both assumptions. It always drives defined samples: directed corner pixels, a grey ramp and pseudo-random pixels, with random valid gaps between them. It asserts reset at time zero and again in the middle of a stream with pixels in flight.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int unsigned PIX_W   = 8;
  localparam int unsigned SHIFT_N = 10;   // shift amounts 0..SHIFT_N-1
  localparam int unsigned ACC_W   = 20;   // covers +447780 / -232560
  localparam int unsigned NORM_SH = 11;
  localparam int unsigned STAGES  = 5;
  localparam int unsigned N_COL   = 3;    // 0 red, 1 green, 2 blue
  localparam int unsigned SPLIT   = SHIFT_N / 2;

  typedef logic signed [ACC_W-1:0] acc_t;
  typedef logic [N_COL*SHIFT_N-1:0] mask_t;

  // per output channel: {blue, green, red} shift masks, bit k = term x<<k
  localparam mask_t CH_MASKS [N_COL] = '{
    {10'h0E0, 10'h3FC, 10'h200},   // luma
    {10'h384, 10'h250, 10'h12C},   // blue-difference
    {10'h090, 10'h300, 10'h391}    // red-difference
  };
  // subtract flag per colour, bit c = colour c
  localparam logic [N_COL-1:0] CH_NEG [N_COL] = '{3'b000, 3'b011, 3'b110};
  localparam int CH_OFF [N_COL] = '{16, 128, 128};

  function automatic acc_t part_sum(input logic [PIX_W-1:0] x,
                                    input logic [SHIFT_N-1:0] mask,
                                    input int lo, input int hi);
    acc_t s;
    acc_t xe;
    s  = '0;
    xe = acc_t'({{(ACC_W-PIX_W){1'b0}}, x});
    for (int k = 0; k < int'(SHIFT_N); k++) begin
      if (k >= lo && k < hi && mask[k]) s = s + (xe <<< k);
    end
    return s;
  endfunction
endpackage

// File: rtl/csc_vld_pipe.sv
module csc_vld_pipe #(
  parameter int unsigned DEPTH = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  output logic vld_o
);
  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[DEPTH-2:0], vld_i};
  end

  assign vld_o = sr_q[DEPTH-1];
endmodule

// File: rtl/csc_lane.sv
module csc_lane import csc_pkg::*; #(
  parameter mask_t            MASKS  = '0,
  parameter logic [N_COL-1:0] NEG    = '0,
  parameter int               OFFSET = 0
) (
  input  logic                       clk_i,
  input  logic [N_COL-1:0][PIX_W-1:0] px_i,
  output logic [PIX_W-1:0]           res_o
);
  localparam acc_t OFF_A = acc_t'(OFFSET);
  localparam acc_t MAX_A = acc_t'((1 << PIX_W) - 1);

  acc_t s1_lo [N_COL];
  acc_t s1_hi [N_COL];
  acc_t s2_t  [N_COL];
  acc_t s3_rg, s3_b, s4_q;
  logic [PIX_W-1:0] s5_q;

  for (genvar c = 0; c < N_COL; c++) begin : g_col
    // stage 1: low and high shift groups
    always_ff @(posedge clk_i) begin
      s1_lo[c] <= part_sum(px_i[c], MASKS[c*SHIFT_N +: SHIFT_N], 0, SPLIT);
      s1_hi[c] <= part_sum(px_i[c], MASKS[c*SHIFT_N +: SHIFT_N], SPLIT, SHIFT_N);
    end
    // stage 2: signed colour term
    if (NEG[c]) begin : g_sub
      always_ff @(posedge clk_i) s2_t[c] <= acc_t'(0) - s1_lo[c] - s1_hi[c];
    end else begin : g_add
      always_ff @(posedge clk_i) s2_t[c] <= s1_lo[c] + s1_hi[c];
    end
  end

  // stage 3: red + green, blue carried
  always_ff @(posedge clk_i) begin
    s3_rg <= s2_t[0] + s2_t[1];
    s3_b  <= s2_t[2];
  end

  // stage 4: total, floor divide, offset
  always_ff @(posedge clk_i) s4_q <= ((s3_rg + s3_b) >>> NORM_SH) + OFF_A;

  // stage 5: clamp
  always_ff @(posedge clk_i) begin
    if (s4_q < acc_t'(0))  s5_q <= '0;
    else if (s4_q > MAX_A) s5_q <= MAX_A[PIX_W-1:0];
    else                   s5_q <= s4_q[PIX_W-1:0];
  end

  assign res_o = s5_q;
endmodule

// File: rtl/rgb_ycc_shiftadd.sv
module rgb_ycc_shiftadd import csc_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [PIX_W-1:0] red_i,
  input  logic [PIX_W-1:0] grn_i,
  input  logic [PIX_W-1:0] blu_i,
  output logic             out_valid_o,
  output logic [PIX_W-1:0] luma_o,
  output logic [PIX_W-1:0] cb_o,
  output logic [PIX_W-1:0] cr_o
);
  logic [N_COL-1:0][PIX_W-1:0] px;
  logic [N_COL-1:0][PIX_W-1:0] res;

  assign px = {blu_i, grn_i, red_i};

  for (genvar ch = 0; ch < N_COL; ch++) begin : g_lane
    csc_lane #(
      .MASKS (CH_MASKS[ch]),
      .NEG   (CH_NEG[ch]),
      .OFFSET(CH_OFF[ch])
    ) u_lane (
      .clk_i(clk_i),
      .px_i (px),
      .res_o(res[ch])
    );
  end

  csc_vld_pipe #(.DEPTH(STAGES)) u_vld (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (in_valid_i),
    .vld_o (out_valid_o)
  );

  assign luma_o = res[0];
  assign cb_o   = res[1];
  assign cr_o   = res[2];
endmodule

// File: rtl/rgb_ycc_shiftadd_chk.sv
module rgb_ycc_shiftadd_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic [7:0] red_i,
  input logic [7:0] grn_i,
  input logic [7:0] blu_i,
  input logic       out_valid_o,
  input logic [7:0] luma_o,
  input logic [7:0] cb_o,
  input logic [7:0] cr_o
);
  logic [2:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             since_rst <= '0;
    else if (since_rst != 5) since_rst <= since_rst + 3'd1;
  end

  // R6
  lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd5) |-> (out_valid_o == $past(in_valid_i, 5)));

  // R8
  rst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 3'd5) |-> !out_valid_o);

  // R5
  range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (luma_o >= 8'd16 && luma_o <= 8'd234 &&
                     cb_o >= 8'd16 && cb_o <= 8'd240 &&
                     cr_o >= 8'd14 && cr_o <= 8'd241));

  // R1
  black_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd5 &&
     $past(in_valid_i && red_i == 8'd0 && grn_i == 8'd0 && blu_i == 8'd0, 5))
    |-> (luma_o == 8'd16 && cb_o == 8'd128 && cr_o == 8'd128));

  // R7
  known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !$isunknown({luma_o, cb_o, cr_o}));
endmodule

bind rgb_ycc_shiftadd rgb_ycc_shiftadd_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .red_i      (red_i),
  .grn_i      (grn_i),
  .blu_i      (blu_i),
  .out_valid_o(out_valid_o),
  .luma_o     (luma_o),
  .cb_o       (cb_o),
  .cr_o       (cr_o)
);

// File: tb/rgb_ycc_shiftadd_tb_top.sv
module rgb_ycc_shiftadd_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 5;

  typedef struct {
    bit v;
    int y;
    int cb;
    int cr;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_v = 1'b0;
  logic [7:0] r_in = '0, g_in = '0, b_in = '0;
  logic       out_v;
  logic [7:0] y_o, cb_o, cr_o;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;
  exp_t hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rgb_ycc_shiftadd dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_v),
    .red_i(r_in), .grn_i(g_in), .blu_i(b_in),
    .out_valid_o(out_v), .luma_o(y_o), .cb_o(cb_o), .cr_o(cr_o)
  );

  function automatic int fdiv(int s);
    return s >>> 11;
  endfunction

  function automatic int clamp8(int v);
    return (v < 0) ? 0 : (v > 255) ? 255 : v;
  endfunction

  function automatic exp_t model(bit v, int r, int g, int b);
    exp_t e;
    e.v  = v;
    e.y  = clamp8(fdiv(512*r + 1020*g + 224*b) + 16);
    e.cb = clamp8(fdiv(900*b - 300*r - 592*g) + 128);
    e.cr = clamp8(fdiv(913*r - 768*g - 144*b) + 128);
    return e;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    exp_t e;
    if (hist.size() < LAT) begin
      chk("R8 out_valid", int'(out_v), 0);
    end else begin
      e = hist[hist.size()-LAT];
      chk("R6 out_valid", int'(out_v), int'(e.v));
      if (e.v && out_v) begin
        chk("R1 luma", int'(y_o), e.y);
        chk("R2 cb", int'(cb_o), e.cb);
        chk("R3 cr", int'(cr_o), e.cr);
        chk("R5 range", int'(y_o >= 16 && y_o <= 234 && cb_o >= 16 &&
            cb_o <= 240 && cr_o >= 14 && cr_o <= 241), 1);
      end
    end
  endtask

  task automatic step(bit v, int r, int g, int b);
    @(negedge clk);
    compare();
    in_v = v;
    r_in = 8'(r);
    g_in = 8'(g);
    b_in = 8'(b);
    hist.push_back(model(v, r, g, b));
    if (hist.size() > 16) void'(hist.pop_front());
  endtask

  task automatic pix(int r, int g, int b);
    step(1'b1, r, g, b);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0);
  endtask

  initial begin
    idle(3);                       // reset held, R8
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R1 R2 R3 corners, black first
    pix(0, 0, 0);
    pix(255, 255, 255);
    pix(255, 0, 0);
    pix(0, 255, 0);
    pix(0, 0, 255);
    pix(1, 0, 0);                  // R4: cb floors to 127
    pix(0, 0, 1);                  // R4: cr floors to 127
    pix(0, 255, 255);              // R5: cr minimum 14
    pix(255, 255, 0);
    idle(6);
    begin
      exp_t e;
      e = model(1, 1, 0, 0);
      chk("R4 cb model", e.cb, 127);
      e = model(1, 0, 0, 1);
      chk("R4 cr model", e.cr, 127);
    end
    // R7 back-to-back grey ramp
    for (int i = 0; i < 256; i++) pix(i, i, i);
    // R7 random stream with gaps
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(3) == 0) step(1'b0, 0, 0, 0);
      else pix(int'($urandom_range(255)), int'($urandom_range(255)),
               int'($urandom_range(255)));
    end
    // R8 reset with pixels in flight
    pix(10, 20, 30);
    pix(40, 50, 60);
    pix(70, 80, 90);
    @(negedge clk);
    compare();
    rst_n = 1'b0;
    in_v  = 1'b0;
    foreach (hist[k]) hist[k].v = 1'b0;
    hist.push_back(model(0, 0, 0, 0));
    #1;
    chk("R8 async clear", int'(out_v), 0);
    idle(3);
    @(negedge clk);
    rst_n = 1'b1;
    hist.delete();
    for (int i = 0; i < 40; i++) pix(i * 6, 255 - i * 6, (i * 37) % 256);
    idle(8);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule